// File: doc/BRIEF.md
# Boundary-Scan Pin Control Register

This block is a serial test register that sits between a chip's core logic and a small group of its pins. Each of several output pins has two cells in the register: one for its data and one for its output enable. Each input pin has one cell. Every cell has two stages. A capture/shift flop takes a snapshot of the live signals or passes data along the serial path. An update latch holds a stable value that can be placed on the pins or on the core inputs.

A separate instruction decoder selects the operating mode. The modes are functional, sample/preload, external test, internal test, clamp and high impedance. A separate test-port controller supplies the capture, shift and update strobes. Serial data enters on `tdi` and leaves on `tdo`, which goes toward the shared output multiplexer.

Capture and shift act on the rising test clock edge. The update latches load on the falling edge of the cycle in which the update strobe is high. The update latches hold their values while data is being captured or shifted, so the pins do not ripple.

Top module: `bscan_pins`

## Requirements
- R1: In functional mode (code 0, and the unused codes 6 and 7), `pin_out`/`pin_oe` equal `core_out`/`core_oe`, and `core_in` equals `pin_in`.
- R2: In sample/preload mode (code 1), a capture loads the register with the live signals and the pins stay functional. The register is laid out with bit 0 nearest `tdo`: bits [N_IN-1:0] take `pin_in`, bits [N_IN+N_OUT-1:N_IN] take `core_out`, and the top N_OUT bits take `core_oe`.
- R3: In sample/preload mode, data shifted in and then updated is held in the update latches while the pins stay functional. A later switch to external-test mode puts that data on the pins with no further update.
- R4: Shifting moves the register one bit toward `tdo` on each rising edge with `shift_dr` high. `tdi` enters the top bit and `tdo` shows bit 0.
- R5: In external-test mode (code 2), `pin_out` and `pin_oe` come from the data and enable update latches. A capture records `pin_in` into the input cells.
- R6: In internal-test mode (code 3), `core_in` comes from the input-cell update latches and the pins are driven from the update latches. A capture records `core_out` into the data cells.
- R7: In clamp mode (code 4), the pins are driven from the update latches. Capture, shift and update strobes have no effect on the register or the pins.
- R8: In high-impedance mode (code 5), every `pin_oe` bit is 0 and `pin_out` follows `core_out`.
- R9: The update latches change only on an update strobe in modes 1 to 3. Capture and shift leave the pins unchanged.
- R10: While `trst_n` is low, the pins and `core_in` are functional in any mode, and all cells clear to 0. Release is synchronised to the test clock over two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| mode | input | 3 | Operating mode from the instruction decoder |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (register bit 0) |
| core_out | input | N_OUT | Core output data |
| core_oe | input | N_OUT | Core output enables |
| core_in | output | N_IN | Values presented to core inputs |
| pin_in | input | N_IN | Values from the input pins |
| pin_out | output | N_OUT | Values toward the output pins |
| pin_oe | output | N_OUT | Output pin enables (0 = high impedance) |

## Verification
Distinct patterns are shifted through the register in turn, including alternating values, so that a swapped cell or a reversed shift direction shows up in the bits read back. Each pattern is applied in sample/preload, external-test and internal-test modes. This separates where the capture source comes from in each mode, and whether the pins or `core_in` follow the latches or the live signals. Strobes sent in clamp mode and a shift done before an update in external-test mode show whether the latches are truly held. A reset asserted during external test shows that the pins fall back to core control.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [2:0] {
    MD_FUNC   = 3'd0,
    MD_SAMPLE = 3'd1,
    MD_EXTEST = 3'd2,
    MD_INTEST = 3'd3,
    MD_CLAMP  = 3'd4,
    MD_HIGHZ  = 3'd5
  } bs_mode_e;
endpackage

// File: rtl/bscan_rst_sync.sv
module bscan_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shf_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic si,
  output logic so,
  output logic q
);
  logic sh_q, sh_d;
  logic up_q, up_d;

  always_comb begin
    sh_d = sh_q;
    if (cap_en)      sh_d = cap_d;
    else if (shf_en) sh_d = si;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 1'b0;
    else        sh_q <= sh_d;
  end

  always_comb up_d = upd_en ? sh_q : up_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= up_d;
  end

  assign so = sh_q;
  assign q  = up_q;
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int LEN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic           shf_en,
  input  logic           upd_en,
  input  logic [LEN-1:0] cap_d,
  input  logic           tdi,
  output logic           tdo,
  output logic [LEN-1:0] upd_q
);
  logic [LEN-1:0] so;
  logic [LEN-1:0] si;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    if (i == LEN - 1) begin : g_top
      assign si[i] = tdi;
    end else begin : g_mid
      assign si[i] = so[i+1];
    end
    bscan_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en),
      .shf_en (shf_en),
      .upd_en (upd_en),
      .cap_d  (cap_d[i]),
      .si     (si[i]),
      .so     (so[i]),
      .q      (upd_q[i])
    );
  end

  assign tdo = so[0];
endmodule

// File: rtl/bscan_pin_mux.sv
module bscan_pin_mux
  import bscan_pkg::*;
#(
  parameter int N_OUT = 3,
  parameter int N_IN  = 2
) (
  input  logic [2:0]       mode,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] lat_dat,
  input  logic [N_OUT-1:0] lat_oe,
  input  logic [N_IN-1:0]  lat_in,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe,
  output logic [N_IN-1:0]  core_in
);
  logic drive_test, feed_core, force_z;

  always_comb begin
    drive_test = 1'b0;
    feed_core  = 1'b0;
    force_z    = 1'b0;
    if (rst_n) begin
      case (mode)
        MD_EXTEST: drive_test = 1'b1;
        MD_INTEST: begin drive_test = 1'b1; feed_core = 1'b1; end
        MD_CLAMP:  drive_test = 1'b1;
        MD_HIGHZ:  force_z    = 1'b1;
        default:   ;
      endcase
    end
    pin_out = drive_test ? lat_dat : core_out;
    pin_oe  = force_z ? '0 : (drive_test ? lat_oe : core_oe);
    core_in = feed_core ? lat_in : pin_in;
  end
endmodule

// File: rtl/bscan_pins.sv
module bscan_pins
  import bscan_pkg::*;
#(
  parameter int N_OUT = 3,
  parameter int N_IN  = 2
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic [2:0]       mode,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe
);
  localparam int LEN    = N_IN + 2 * N_OUT;
  localparam int DAT_LO = N_IN;
  localparam int OE_LO  = N_IN + N_OUT;

  logic           rst_n_s;
  logic           chain_sel;
  logic [LEN-1:0] cap_vec;
  logic [LEN-1:0] lat;

  bscan_rst_sync u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n_s)
  );

  always_comb begin
    chain_sel = (mode == MD_SAMPLE) || (mode == MD_EXTEST) || (mode == MD_INTEST);
    cap_vec   = {core_oe, core_out, pin_in};
  end

  bscan_chain #(.LEN(LEN)) u_chain (
    .clk    (tck),
    .rst_n  (rst_n_s),
    .cap_en (chain_sel & capture_dr),
    .shf_en (chain_sel & shift_dr),
    .upd_en (chain_sel & update_dr),
    .cap_d  (cap_vec),
    .tdi    (tdi),
    .tdo    (tdo),
    .upd_q  (lat)
  );

  bscan_pin_mux #(.N_OUT(N_OUT), .N_IN(N_IN)) u_mux (
    .mode     (mode),
    .rst_n    (rst_n_s),
    .core_out (core_out),
    .core_oe  (core_oe),
    .pin_in   (pin_in),
    .lat_dat  (lat[OE_LO-1:DAT_LO]),
    .lat_oe   (lat[LEN-1:OE_LO]),
    .lat_in   (lat[N_IN-1:0]),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .core_in  (core_in)
  );
endmodule

// File: rtl/bscan_pins_chk.sv
module bscan_pins_chk #(
  parameter int N_OUT = 3,
  parameter int N_IN  = 2
) (
  input logic             tck,
  input logic             trst_n,
  input logic             rst_n_s,
  input logic [2:0]       mode,
  input logic             update_dr,
  input logic [N_OUT-1:0] core_out,
  input logic [N_OUT-1:0] core_oe,
  input logic [N_IN-1:0]  core_in,
  input logic [N_IN-1:0]  pin_in,
  input logic [N_OUT-1:0] pin_out,
  input logic [N_OUT-1:0] pin_oe
);
  a_r1_func_pins: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 3'd0) |-> (pin_out == core_out && pin_oe == core_oe && core_in == pin_in));

  a_r6_core_in_src: assert property (@(posedge tck) disable iff (!trst_n)
    (mode != 3'd3) |-> (core_in == pin_in));

  a_r7_clamp_hold: assert property (@(posedge tck) disable iff (!rst_n_s)
    (mode == 3'd4 && $past(mode) == 3'd4 && $past(rst_n_s)) |-> ($stable(pin_out) && $stable(pin_oe)));

  a_r8_highz_all: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 3'd5) |-> (pin_oe == '0));

  a_r9_no_ripple: assert property (@(posedge tck) disable iff (!rst_n_s)
    (mode == 3'd2 && $past(mode) == 3'd2 && $past(rst_n_s) && !update_dr && !$past(update_dr))
      |-> ($stable(pin_out) && $stable(pin_oe)));

  a_r10_reset_func: assert property (@(posedge tck)
    (!trst_n) |-> (pin_out == core_out && pin_oe == core_oe && core_in == pin_in));
endmodule

bind bscan_pins bscan_pins_chk #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
  .tck       (tck),
  .trst_n    (trst_n),
  .rst_n_s   (rst_n_s),
  .mode      (mode),
  .update_dr (update_dr),
  .core_out  (core_out),
  .core_oe   (core_oe),
  .core_in   (core_in),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/bscan_pins_test.sv
module bscan_pins_test;
  localparam int NO  = 3;
  localparam int NI  = 2;
  localparam int LEN = NI + 2 * NO;

  logic          tck = 1'b0;
  logic          trst_n;
  logic [2:0]    mode;
  logic          capture_dr, shift_dr, update_dr, tdi;
  logic          tdo;
  logic [NO-1:0] core_out, core_oe, pin_out, pin_oe;
  logic [NI-1:0] pin_in, core_in;

  int errors = 0;
  int checks = 0;
  logic [LEN-1:0] rd;

  always #5 tck = ~tck;

  bscan_pins #(.N_OUT(NO), .N_IN(NI)) uut (
    .tck(tck), .trst_n(trst_n), .mode(mode), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick_set;
    @(posedge tck); #1;
  endtask

  task automatic do_capture;
    tick_set(); capture_dr = 1'b1;
    tick_set(); capture_dr = 1'b0;
  endtask

  task automatic do_update;
    tick_set(); update_dr = 1'b1;
    tick_set(); update_dr = 1'b0;
  endtask

  task automatic shift_io(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
    for (int i = 0; i < LEN; i++) begin
      tick_set();
      dout[i]  = tdo;
      shift_dr = 1'b1;
      tdi      = din[i];
    end
    tick_set();
    shift_dr = 1'b0;
  endtask

  function automatic logic [LEN-1:0] pk(input logic [NO-1:0] oe, input logic [NO-1:0] d,
                                        input logic [NI-1:0] in);
    return {oe, d, in};
  endfunction

  task automatic t_reset;
    chk("R10 reset pin_out", 32'(pin_out), 32'(core_out));
    chk("R10 reset pin_oe", 32'(pin_oe), 32'(core_oe));
    chk("R10 reset tdo", 32'(tdo), 32'd0);
    chk("R1 func core_in", 32'(core_in), 32'(pin_in));
  endtask

  task automatic t_sample;
    mode = 3'd1; core_out = 3'b101; core_oe = 3'b011; pin_in = 2'b10;
    do_capture();
    chk("R2 sample pins functional", 32'({pin_oe, pin_out}), 32'({core_oe, core_out}));
    shift_io(pk(3'b110, 3'b010, 2'b01), rd);
    chk("R2 R4 sample capture readout", 32'(rd), 32'(pk(3'b011, 3'b101, 2'b10)));
    do_update();
    chk("R3 preload pins untouched", 32'({pin_oe, pin_out}), 32'({core_oe, core_out}));
    mode = 3'd2; #1;
    chk("R3 preload reaches pins in extest", 32'({pin_oe, pin_out}), 32'({3'b110, 3'b010}));
  endtask

  task automatic t_extest;
    pin_in = 2'b01; core_out = 3'b000; core_oe = 3'b000;
    do_capture();
    chk("R9 capture keeps pins", 32'({pin_oe, pin_out}), 32'({3'b110, 3'b010}));
    shift_io(pk(3'b001, 3'b101, 2'b11), rd);
    chk("R5 extest input capture", 32'(rd[NI-1:0]), 32'(2'b01));
    chk("R9 shift keeps pins", 32'({pin_oe, pin_out}), 32'({3'b110, 3'b010}));
    do_update();
    chk("R5 extest pins from latches", 32'({pin_oe, pin_out}), 32'({3'b001, 3'b101}));
  endtask

  task automatic t_intest;
    mode = 3'd3; pin_in = 2'b00;
    shift_io(pk(3'b111, 3'b011, 2'b10), rd);
    do_update();
    chk("R6 intest core_in from latches", 32'(core_in), 32'(2'b10));
    chk("R6 intest pins from latches", 32'({pin_oe, pin_out}), 32'({3'b111, 3'b011}));
    core_out = 3'b110;
    do_capture();
    shift_io(pk(3'b111, 3'b011, 2'b10), rd);
    chk("R6 intest core response captured", 32'(rd[NI+NO-1:NI]), 32'(3'b110));
  endtask

  task automatic t_clamp;
    mode = 3'd4;
    do_capture();
    shift_io(pk(3'b000, 3'b000, 2'b00), rd);
    do_update();
    chk("R7 clamp ignores strobes", 32'({pin_oe, pin_out}), 32'({3'b111, 3'b011}));
    mode = 3'd3; #1;
    chk("R7 clamp left latches", 32'(core_in), 32'(2'b10));
  endtask

  task automatic t_highz;
    mode = 3'd5; core_out = 3'b011; core_oe = 3'b111; #1;
    chk("R8 highz oe", 32'(pin_oe), 32'd0);
    chk("R8 highz data", 32'(pin_out), 32'(core_out));
    mode = 3'd7; #1;
    chk("R1 unused code functional", 32'({pin_oe, pin_out}), 32'({core_oe, core_out}));
    mode = 3'd0; #1;
    chk("R1 func pins", 32'({pin_oe, pin_out}), 32'({core_oe, core_out}));
  endtask

  task automatic t_reset_mid;
    mode = 3'd2; core_out = 3'b100; core_oe = 3'b010; pin_in = 2'b11;
    tick_set(); trst_n = 1'b0; #1;
    chk("R10 reset overrides extest", 32'({pin_oe, pin_out}), 32'({core_oe, core_out}));
    tick_set(); trst_n = 1'b1;
    repeat (3) tick_set();
    chk("R10 latches cleared", 32'({pin_oe, pin_out}), 32'd0);
  endtask

  initial begin
    trst_n = 1'b0; mode = 3'd0; capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
    core_out = 3'b010; core_oe = 3'b101; pin_in = 2'b01;
    repeat (3) tick_set();
    t_reset();
    trst_n = 1'b1;
    repeat (3) tick_set();
    t_sample();
    t_extest();
    t_intest();
    t_clamp();
    t_highz();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule